// File: doc/BRIEF.md
# Chained Pool of Shared Correction Entries

This block keeps a shared pool of correction entries. Each entry holds one fault pointer. Entries are given out on demand to memory lines whose local correction is already used up. A line address is split into a set index and a tag. New entries for a line go into the ways of its primary set. Once that set is full, the set claims a whole set of a collision table that has half as many sets. From then on it spills further entries into that collision set. The link is a head pointer kept per primary set in two copies. The copies are compared on every access, and on a mismatch the copy whose valid bit is set is used.

All entries of one line therefore live in one primary set, plus at most one chained collision set. A lookup reads the primary set and, only when a head exists, the chained set. It returns every entry tagged with the line. A line may gather up to twice the way count, which exceeds the usual limit of six. Collision sets are claimed in round order. A status output shows when none are left.

Top module: `gec_pool`

## Requirements
- R1: After reset no entry and no head pointer is valid, `rsp_valid` and `pool_full` are 0, and a lookup of any address returns `rsp_hits` = 0 and `rsp_entries` = 0.
- R2: The set index is `req_addr[SET_W-1:0]` and the tag is the remaining upper bits. Each cycle with `req_valid` = 1 yields `rsp_valid` = 1 in the next cycle. A cycle without a request yields `rsp_valid` = 0 in the next cycle. Entries of another tag, or of another set, never match.
- R3: An allocate (`req_alloc` = 1) whose primary set has a free way writes `req_entry` into the lowest free way and responds with `rsp_ok` = 1 and `rsp_chain` = 0.
- R4: The response packs the entries whose tag matches into `rsp_entries`. Slot k occupies bits `[k*ENT_W +: ENT_W]`. Primary ways come first in ascending way order, then the ways of the chained set in ascending order. Unused slots are zero. `rsp_hits` gives the count. For an allocate, these fields describe the line as it was before the write.
- R5: An allocate into a full primary set with no head claims the next unclaimed collision set. Claims go in order 0, 1, 2, …. The block writes way 0 of that set and records the head in both copies. An allocate into a full primary set that has a head writes the lowest free way of the chained set. Both cases respond `rsp_ok` = 1 and `rsp_chain` = 1.
- R6: A lookup responds `rsp_chain` = 1 exactly when its primary set has a head, and the chained set was then also read. A lookup never sets `rsp_ok`.
- R7: One line can hold 2*WAYS entries (8 with the default parameters), and a lookup returns all of them.
- R8: An allocate fails with `rsp_ok` = 0 and `rsp_chain` = 0, and stores nothing, in either of two cases: the primary set and its chained set are both full, or the primary set is full, has no head and no collision set is left.
- R9: `pool_full` is 1 exactly when all CSETS collision sets have been claimed, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_alloc | input | 1 | 1 = allocate, 0 = lookup |
| req_addr | input | ADDR_W | Line address |
| req_entry | input | ENT_W | Correction pointer entry to store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Allocate succeeded |
| rsp_chain | output | 1 | Collision table touched |
| rsp_hits | output | HIT_W | Number of matching entries |
| rsp_entries | output | 2*WAYS*ENT_W | Matching entries, packed from slot 0 |
| pool_full | output | 1 | No collision set left to claim |

## Verification
Directed patterns come first. One line is filled past its primary set into a chained set, and then past that set too. This separates primary placement, chained placement, packing order and failure. Three more sets are then overflowed to drain the collision table. The bench then overflows one last set that has no head, which isolates the exhausted-pool failure. A seeded random mix of lookups and allocates follows, over few tags per set. It produces partial matches, interleaved tags in one set and mixed primary/chained hits, which test tag filtering and compaction against a bench model of the tables.

// File: rtl/gec_pool.sv
module gec_pool #(
  parameter int ADDR_W = 8,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int ENT_W  = 10,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int CSETS = SETS / 2,
  localparam int CI_W  = $clog2(CSETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NRES  = 2 * WAYS,
  localparam int HIT_W = $clog2(NRES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_alloc,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [ENT_W-1:0]       req_entry,
  output logic                   rsp_valid,
  output logic                   rsp_ok,
  output logic                   rsp_chain,
  output logic [HIT_W-1:0]       rsp_hits,
  output logic [NRES*ENT_W-1:0]  rsp_entries,
  output logic                   pool_full
);

  logic             p_v   [SETS][WAYS];
  logic [TAG_W-1:0] p_tag [SETS][WAYS];
  logic [ENT_W-1:0] p_ent [SETS][WAYS];
  logic             c_v   [CSETS][WAYS];
  logic [TAG_W-1:0] c_tag [CSETS][WAYS];
  logic [ENT_W-1:0] c_ent [CSETS][WAYS];
  logic [CI_W:0]    head_a [SETS];
  logic [CI_W:0]    head_b [SETS];
  logic [CI_W:0]    claimed;

  logic [SET_W-1:0] set;
  logic [TAG_W-1:0] tag;
  logic [CI_W:0]    head;
  logic             hv;
  logic [CI_W-1:0]  hidx;
  logic             pfree, cfree;
  logic [WAY_W-1:0] pway, cway;
  logic [NRES*ENT_W-1:0] slots;
  logic [HIT_W-1:0] hits;
  logic             ok, chain;

  assign set  = req_addr[SET_W-1:0];
  assign tag  = req_addr[ADDR_W-1:SET_W];
  assign head = (head_a[set] == head_b[set]) ? head_a[set] :
                (head_a[set][CI_W] ? head_a[set] : head_b[set]);
  assign hv   = head[CI_W];
  assign hidx = head[CI_W-1:0];
  assign pool_full = (claimed == (CI_W+1)'(CSETS));

  always_comb begin
    pfree = 1'b0; pway = '0; cfree = 1'b0; cway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!p_v[set][w]) begin pfree = 1'b1; pway = WAY_W'(w); end
      if (!c_v[hidx][w]) begin cfree = 1'b1; cway = WAY_W'(w); end
    end
  end

  always_comb begin
    int n;
    n = 0;
    slots = '0;
    for (int w = 0; w < WAYS; w++)
      if (p_v[set][w] && p_tag[set][w] == tag) begin
        slots[n*ENT_W +: ENT_W] = p_ent[set][w];
        n = n + 1;
      end
    if (hv)
      for (int w = 0; w < WAYS; w++)
        if (c_v[hidx][w] && c_tag[hidx][w] == tag) begin
          slots[n*ENT_W +: ENT_W] = c_ent[hidx][w];
          n = n + 1;
        end
    hits = HIT_W'(n);
  end

  always_comb begin
    ok = 1'b0; chain = 1'b0;
    if (!req_alloc) chain = hv;
    else if (pfree) ok = 1'b1;
    else if (hv ? cfree : !pool_full) begin ok = 1'b1; chain = 1'b1; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claimed <= '0;
      for (int s = 0; s < SETS; s++) begin
        head_a[s] <= '0;
        head_b[s] <= '0;
        for (int w = 0; w < WAYS; w++) p_v[s][w] <= 1'b0;
      end
      for (int s = 0; s < CSETS; s++)
        for (int w = 0; w < WAYS; w++) c_v[s][w] <= 1'b0;
    end else if (req_valid && req_alloc && ok) begin
      if (pfree) begin
        p_v[set][pway]   <= 1'b1;
        p_tag[set][pway] <= tag;
        p_ent[set][pway] <= req_entry;
      end else if (hv) begin
        c_v[hidx][cway]   <= 1'b1;
        c_tag[hidx][cway] <= tag;
        c_ent[hidx][cway] <= req_entry;
      end else begin
        c_v[claimed[CI_W-1:0]][0]   <= 1'b1;
        c_tag[claimed[CI_W-1:0]][0] <= tag;
        c_ent[claimed[CI_W-1:0]][0] <= req_entry;
        head_a[set] <= {1'b1, claimed[CI_W-1:0]};
        head_b[set] <= {1'b1, claimed[CI_W-1:0]};
        claimed     <= claimed + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_ok <= 1'b0; rsp_chain <= 1'b0;
      rsp_hits <= '0; rsp_entries <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_ok      <= req_valid && ok;
      rsp_chain   <= req_valid && chain;
      rsp_hits    <= hits;
      rsp_entries <= slots;
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_ok_needs_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_alloc |=> !rsp_ok);
  p_fail_exhausted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_alloc && !pfree && !hv && pool_full |=> rsp_valid && !rsp_ok);
  p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |=> pool_full);
  p_claim_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(claimed) |-> claimed == $past(claimed) + 1'b1);

  for (genvar g = 0; g < SETS; g++) begin : g_head_chk
    p_heads_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
      head_a[g] == head_b[g]);
  end

endmodule

// File: tb/gec_pool_test.sv
`timescale 1ns/1ps
module gec_pool_test;
  localparam int ADDR_W = 8, SETS = 8, WAYS = 4, ENT_W = 10;
  localparam int SET_W = 3, CSETS = 4, NRES = 8, HIT_W = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_alloc = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ENT_W-1:0]  req_entry = '0;
  logic rsp_valid, rsp_ok, rsp_chain, pool_full;
  logic [HIT_W-1:0] rsp_hits;
  logic [NRES*ENT_W-1:0] rsp_entries;

  gec_pool #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .ENT_W(ENT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_alloc(req_alloc),
    .req_addr(req_addr), .req_entry(req_entry), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_chain(rsp_chain), .rsp_hits(rsp_hits),
    .rsp_entries(rsp_entries), .pool_full(pool_full));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;

  // reference tables
  bit       mp_v [SETS][WAYS];
  int       mp_t [SETS][WAYS];
  int       mp_e [SETS][WAYS];
  bit       mc_v [CSETS][WAYS];
  int       mc_t [CSETS][WAYS];
  int       mc_e [CSETS][WAYS];
  bit       mh_v [SETS];
  int       mh_i [SETS];
  int       mclaim = 0;

  task automatic check(input string req, input bit cond, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input bit al, input int a, input int e, input string req);
    int s, t, n, fw;
    logic [NRES*ENT_W-1:0] ex;
    bit e_ok, e_ch;
    s = a % SETS; t = a / SETS; n = 0; ex = '0; e_ok = 0; e_ch = 0;
    for (int w = 0; w < WAYS; w++)
      if (mp_v[s][w] && mp_t[s][w] == t) begin ex[n*ENT_W +: ENT_W] = ENT_W'(mp_e[s][w]); n++; end
    if (mh_v[s])
      for (int w = 0; w < WAYS; w++)
        if (mc_v[mh_i[s]][w] && mc_t[mh_i[s]][w] == t) begin ex[n*ENT_W +: ENT_W] = ENT_W'(mc_e[mh_i[s]][w]); n++; end
    if (!al) e_ch = mh_v[s];
    else begin
      fw = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!mp_v[s][w]) fw = w;
      if (fw >= 0) begin
        e_ok = 1; mp_v[s][fw] = 1; mp_t[s][fw] = t; mp_e[s][fw] = e;
      end else if (mh_v[s]) begin
        for (int w = WAYS - 1; w >= 0; w--) if (!mc_v[mh_i[s]][w]) fw = w;
        if (fw >= 0) begin
          e_ok = 1; e_ch = 1;
          mc_v[mh_i[s]][fw] = 1; mc_t[mh_i[s]][fw] = t; mc_e[mh_i[s]][fw] = e;
        end
      end else if (mclaim < CSETS) begin
        e_ok = 1; e_ch = 1; mh_v[s] = 1; mh_i[s] = mclaim;
        mc_v[mclaim][0] = 1; mc_t[mclaim][0] = t; mc_e[mclaim][0] = e;
        mclaim++;
      end
    end
    req_valid = 1; req_alloc = al; req_addr = ADDR_W'(a); req_entry = ENT_W'(e);
    @(negedge clk);
    req_valid = 0;
    check(req, rsp_valid === 1'b1, "rsp_valid", 128'(rsp_valid), 128'(1));
    check(req, rsp_ok === e_ok && rsp_chain === e_ch, "ok/chain",
          128'({rsp_ok, rsp_chain}), 128'({e_ok, e_ch}));
    check(req, rsp_hits === HIT_W'(n) && rsp_entries === ex, "hits/entries",
          128'({rsp_hits, rsp_entries}), 128'({HIT_W'(n), ex}));
    check("R9", pool_full === (mclaim == CSETS), "pool_full",
          128'(pool_full), 128'(mclaim == CSETS));
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog expected=finish actual=hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin
      mh_v[s] = 0;
      for (int w = 0; w < WAYS; w++) mp_v[s][w] = 0;
    end
    for (int s = 0; s < CSETS; s++) for (int w = 0; w < WAYS; w++) mc_v[s][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", rsp_valid === 1'b0 && pool_full === 1'b0, "reset state",
          128'({rsp_valid, pool_full}), 128'(0));
    do_req(0, 0, 0, "R1 empty lookup");
    do_req(0, 8'hff, 0, "R1 empty lookup");
    @(negedge clk);
    check("R2", rsp_valid === 1'b0, "idle rsp_valid", 128'(rsp_valid), 128'(0));
    // line tag 5, set 2: fill primary, then chain, then overflow
    for (int k = 0; k < 4; k++) do_req(1, 5*8+2, 16'h100 + k, "R3 primary alloc");
    do_req(1, 5*8+2, 16'h1a0, "R5 claim chain");
    for (int k = 0; k < 3; k++) do_req(1, 5*8+2, 16'h1b0 + k, "R5 chained alloc");
    do_req(0, 5*8+2, 0, "R7 eight entries R4 order R6 chain");
    do_req(1, 5*8+2, 16'h2ee, "R8 both full");
    do_req(0, 6*8+2, 0, "R6 chain other tag");
    do_req(0, 5*8+3, 0, "R2 other set");
    // drain the collision table
    for (int s = 3; s <= 5; s++)
      for (int k = 0; k < 5; k++) do_req(1, (k%2)*8 + s, 16'h300 + s*8 + k, "R5 drain");
    for (int k = 0; k < 4; k++) do_req(1, 6, 16'h3c0 + k, "R3 fill set6");
    do_req(1, 6, 16'h3ff, "R8 pool exhausted");
    do_req(0, 6, 0, "R8 nothing stored");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      a = int'($urandom_range(3, 0)) * 8 + int'($urandom_range(7, 0));
      if ($urandom_range(1, 0) == 1) do_req(1, a, int'($urandom_range(1023, 0)), "R3 random alloc");
      else do_req(0, a, 0, "R4 random lookup R2");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule